// File: doc/BRIEF.md
# PD Receive Message Sequencer

This block controls the reception of one USB Power Delivery message. It sits behind the BMC decoder and the ordered-set matcher. From them it takes decoded 5-bit symbols, a pulse for every line transition, a pulse for every preamble bit and a pulse when a valid ordered set has been matched. It walks a message through five states: idle check, preamble, ordered set, payload and end. It leaves two sticky status flags and two single-cycle pulses for the logic around it.

The end-of-packet symbol is watched for on every payload symbol, not only at the position where the message should end. A transmitter that must send a Hard Reset cuts its current message short with an early end-of-packet. The sequencer discards such a message at once, without setting a flag, and returns to the idle check in time for the Hard Reset preamble. A payload that stalls, or that ends with a damaged end symbol, is aborted and reported as a message end with an error.

Before any payload begins, two conditions send the front end back to the idle check: a preamble that is too short, or a line that goes static before the ordered set is complete. Only once the line has been static again may a new message start. The upper layer supplies the expected number of data-plus-CRC symbols for the current message, taken from the header it has decoded.

Top module: `pd_rx_seq`

## Requirements
- R1: After reset, msg_act_o, restart_o, discard_o, rx_msgend_o and rx_err_o are all 0, and the sequencer is in the idle check.
- R2: While in the idle check, preamble bits, symbols and ordered-set pulses are ignored. The idle check ends only after line_edge_i has been low for TMO_CLKS consecutive cycles.
- R3: A symbol seen during the preamble after fewer than PRE_BITS/2 preamble bits gives one restart_o pulse and no payload. No flag changes.
- R4: If the line stays static for TMO_CLKS cycles during the preamble or ordered-set phase, restart_o pulses once, no payload starts and no flag changes.
- R5: The end-of-packet symbol is sym_i == 5'b01101, with bit 0 the first bit on the line. If it arrives when exactly msg_syms_i payload symbols have been received, rx_msgend_o is set, and rx_err_o and discard_o stay 0.
- R6: An end-of-packet symbol that arrives before msg_syms_i payload symbols have been received gives one discard_o pulse and sets no flag.
- R7: If a symbol other than end-of-packet arrives at the expected end position, rx_msgend_o and rx_err_o are set and discard_o pulses.
- R8: If the line is static during the payload, the message is aborted: rx_msgend_o and rx_err_o are set and discard_o pulses, exactly TMO_CLKS+1 cycles after the cycle of the last edge, which is under 3 UI at the default of 2 UI.
- R9: rx_msgend_o (clr_i bit 0) and rx_err_o (clr_i bit 1) stay set until a one is written to their own clr_i bit. A clear bit touches only its own flag.
- R10: msg_act_o rises only on an ordered-set pulse received in the ordered-set phase. It stays high until the message ends, is discarded or is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | A decoded symbol is present on sym_i |
| sym_i | input | 5 | Decoded 5-bit symbol |
| line_edge_i | input | 1 | Pulse on each CC line transition |
| pre_bit_i | input | 1 | Pulse on each preamble bit |
| ordset_det_i | input | 1 | Pulse when the ordered set is matched |
| msg_syms_i | input | CNT_W | Expected number of payload symbols (data and CRC) before the end symbol |
| clr_i | input | 2 | Write-one-to-clear: bit 0 clears msgend, bit 1 clears err |
| msg_act_o | output | 1 | Payload reception in progress |
| restart_o | output | 1 | Pulse: front end must restart clock recovery |
| discard_o | output | 1 | Pulse: the partial message must be dropped |
| rx_msgend_o | output | 1 | Sticky: message reception finished |
| rx_err_o | output | 1 | Sticky: message ended in error |

## Verification
The bench drives whole messages with random preamble lengths, payload lengths and endings. It places preambles on both sides of the half-length threshold; a wrong comparison would start payloads it should reject, or reject valid ones. It places early end symbols at random payload positions; a decoder that checks only at the expected end would let a truncated message through, or flag it as an error. It measures the payload stall timeout to the cycle and clears each sticky flag on its own, which exposes an off-by-one timer or cross-wired clear bits. It also sends preamble and ordered-set activity straight after reset and an ordered-set pulse while idle, so a sequencer that skips the idle check or accepts a stray match shows up.

// File: rtl/pd_rx_pkg.sv
package pd_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_CHK = 3'd0,
    ST_IDLE     = 3'd1,
    ST_PRE      = 3'd2,
    ST_ORDSET   = 3'd3,
    ST_PAYLOAD  = 3'd4,
    ST_END      = 3'd5
  } rx_state_e;

  localparam logic [4:0] EOP_SYM = 5'b01101;
endpackage

// File: rtl/pd_rx_static_timer.sv
module pd_rx_static_timer #(
  parameter int TMO_CLKS = 16,
  localparam int TW = $clog2(TMO_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (edge_i)                     cnt_q <= '0;
    else if (cnt_q != TW'(TMO_CLKS))     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == TW'(TMO_CLKS));
endmodule

// File: rtl/pd_rx_fsm.sv
module pd_rx_fsm
  import pd_rx_pkg::*;
#(
  parameter int PRE_BITS = 64,
  parameter int CNT_W    = 7,
  localparam int PRE_MIN = PRE_BITS / 2,
  localparam int PW      = $clog2(PRE_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_valid_i,
  input  logic [4:0]       sym_i,
  input  logic             pre_bit_i,
  input  logic             ordset_det_i,
  input  logic             expired_i,
  input  logic [CNT_W-1:0] msg_syms_i,
  output logic             set_end_o,
  output logic             set_err_o,
  output logic             discard_o,
  output logic             restart_o,
  output logic             msg_act_o
);
  rx_state_e        st_q, st_d;
  logic [PW-1:0]    pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             disc_d, rst_d;
  logic             is_eop;

  assign is_eop = (sym_i == EOP_SYM);

  always_comb begin
    st_d      = st_q;
    pre_d     = pre_q;
    cnt_d     = cnt_q;
    set_end_o = 1'b0;
    set_err_o = 1'b0;
    disc_d    = 1'b0;
    rst_d     = 1'b0;
    unique case (st_q)
      ST_IDLE_CHK: if (expired_i) st_d = ST_IDLE;
      ST_IDLE: begin
        if (pre_bit_i) begin
          st_d  = ST_PRE;
          pre_d = PW'(1);
        end
      end
      ST_PRE: begin
        if (pre_bit_i && pre_q != PW'(PRE_BITS)) pre_d = pre_q + 1'b1;
        if (expired_i) begin
          st_d  = ST_IDLE_CHK;
          rst_d = 1'b1;
        end else if (sym_valid_i) begin
          if (pre_q < PW'(PRE_MIN)) begin
            st_d  = ST_IDLE_CHK;
            rst_d = 1'b1;
          end else begin
            st_d = ST_ORDSET;
          end
        end
      end
      ST_ORDSET: begin
        if (expired_i) begin
          st_d  = ST_IDLE_CHK;
          rst_d = 1'b1;
        end else if (ordset_det_i) begin
          st_d  = ST_PAYLOAD;
          cnt_d = '0;
        end
      end
      ST_PAYLOAD: begin
        if (expired_i) begin
          // stalled line: abort with error
          st_d      = ST_END;
          set_end_o = 1'b1;
          set_err_o = 1'b1;
          disc_d    = 1'b1;
        end else if (sym_valid_i) begin
          if (cnt_q == msg_syms_i) begin
            st_d      = ST_END;
            set_end_o = 1'b1;
            if (!is_eop) begin
              set_err_o = 1'b1;
              disc_d    = 1'b1;
            end
          end else if (is_eop) begin
            // truncated message ahead of a hard reset
            st_d   = ST_IDLE_CHK;
            disc_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_END:  st_d = ST_IDLE_CHK;
      default: st_d = ST_IDLE_CHK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE_CHK;
      pre_q     <= '0;
      cnt_q     <= '0;
      discard_o <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      pre_q     <= pre_d;
      cnt_q     <= cnt_d;
      discard_o <= disc_d;
      restart_o <= rst_d;
    end
  end

  assign msg_act_o = (st_q == ST_PAYLOAD);
endmodule

// File: rtl/pd_rx_flags.sv
module pd_rx_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pd_rx_seq.sv
module pd_rx_seq #(
  parameter int PRE_BITS = 64,
  parameter int TMO_CLKS = 16,
  parameter int MAX_SYMS = 80,
  localparam int CNT_W   = $clog2(MAX_SYMS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_valid_i,
  input  logic [4:0]       sym_i,
  input  logic             line_edge_i,
  input  logic             pre_bit_i,
  input  logic             ordset_det_i,
  input  logic [CNT_W-1:0] msg_syms_i,
  input  logic [1:0]       clr_i,
  output logic             msg_act_o,
  output logic             restart_o,
  output logic             discard_o,
  output logic             rx_msgend_o,
  output logic             rx_err_o
);
  logic       expired;
  logic       set_end, set_err;
  logic [1:0] flags;

  pd_rx_static_timer #(.TMO_CLKS(TMO_CLKS)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (line_edge_i),
    .expired_o (expired)
  );

  pd_rx_fsm #(.PRE_BITS(PRE_BITS), .CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sym_valid_i  (sym_valid_i),
    .sym_i        (sym_i),
    .pre_bit_i    (pre_bit_i),
    .ordset_det_i (ordset_det_i),
    .expired_i    (expired),
    .msg_syms_i   (msg_syms_i),
    .set_end_o    (set_end),
    .set_err_o    (set_err),
    .discard_o    (discard_o),
    .restart_o    (restart_o),
    .msg_act_o    (msg_act_o)
  );

  pd_rx_flags #(.NFLAG(2)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({set_err, set_end}),
    .clr_i  (clr_i),
    .flag_o (flags)
  );

  assign rx_msgend_o = flags[0];
  assign rx_err_o    = flags[1];
endmodule

// File: rtl/pd_rx_seq_chk.sv
module pd_rx_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ordset_det_i,
  input logic [1:0] clr_i,
  input logic       set_end,
  input logic       set_err,
  input logic       msg_act_o,
  input logic       restart_o,
  input logic       discard_o,
  input logic       rx_msgend_o,
  input logic       rx_err_o
);
  // R4: a restart never coincides with a discard
  a_r4_restart_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restart_o && discard_o));

  // R3, R4: restarts leave the flags untouched
  a_r3_restart_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> ($stable(rx_msgend_o) && $stable(rx_err_o)));

  // R10: payload starts only on an ordered-set match
  a_r10_act_on_os: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_act_o) |-> $past(ordset_det_i));

  // R5, R6: payload leaves through end flag or discard
  a_r5_act_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(msg_act_o) |-> (rx_msgend_o || discard_o));

  // R7, R8: error rises with msgend and discard
  a_r8_err_with_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_err_o) |-> (rx_msgend_o && discard_o));

  // R9: a clear without a set empties the flag
  a_r9_clr_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !set_end) |=> !rx_msgend_o);

  a_r9_clr_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[1] && !set_err) |=> !rx_err_o);
endmodule

bind pd_rx_seq pd_rx_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ordset_det_i (ordset_det_i),
  .clr_i        (clr_i),
  .set_end      (set_end),
  .set_err      (set_err),
  .msg_act_o    (msg_act_o),
  .restart_o    (restart_o),
  .discard_o    (discard_o),
  .rx_msgend_o  (rx_msgend_o),
  .rx_err_o     (rx_err_o)
);

// File: tb/pd_rx_seq_test.sv
`timescale 1ns/1ps
module pd_rx_seq_test;
  localparam int PRE_BITS = 64;
  localparam int TMO_CLKS = 16;
  localparam int MAX_SYMS = 80;
  localparam int CNT_W    = $clog2(MAX_SYMS + 1);
  localparam logic [4:0] EOP = 5'b01101;
  localparam int K_OSTMO = 0, K_GOOD = 1, K_EARLY = 2, K_BAD = 3, K_PTMO = 4;

  logic clk = 0, rst_n = 0;
  logic sv = 0, e = 0, pb = 0, od = 0;
  logic [4:0] s = '0;
  logic [CNT_W-1:0] nsyms = '0;
  logic [1:0] clr = '0;
  logic act, rst_p, disc, mend, err;

  int n_run = 0, n_fail = 0;
  int c_rst = 0, c_disc = 0, c_act = 0;

  always #4 clk = ~clk;

  pd_rx_seq #(.PRE_BITS(PRE_BITS), .TMO_CLKS(TMO_CLKS), .MAX_SYMS(MAX_SYMS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sv), .sym_i(s), .line_edge_i(e),
    .pre_bit_i(pb), .ordset_det_i(od), .msg_syms_i(nsyms), .clr_i(clr),
    .msg_act_o(act), .restart_o(rst_p), .discard_o(disc),
    .rx_msgend_o(mend), .rx_err_o(err));

  always @(negedge clk) begin
    if (rst_p) c_rst++;
    if (disc)  c_disc++;
    if (act)   c_act++;
  end

  task automatic chk(input string req, input int act_v, input int exp_v);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic step(input logic ie, input logic ip, input logic isv,
                      input logic [4:0] is, input logic iod);
    e = ie; pb = ip; sv = isv; s = is; od = iod;
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 5'd0, 0);
  endtask

  function automatic logic [4:0] rnd_sym();
    logic [4:0] v;
    do v = 5'($urandom); while (v == EOP);
    return v;
  endfunction

  // expected {restart, discard, msgend, err}
  function automatic logic [3:0] expect_of(input int pre_n, input int kind);
    if (pre_n < PRE_BITS / 2) return 4'b1000;
    case (kind)
      K_OSTMO: return 4'b1000;
      K_GOOD:  return 4'b0010;
      K_EARLY: return 4'b0100;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic send_msg(input int pre_n, input int kind, input int n, input int pos);
    for (int i = 0; i < pre_n; i++) step(1, 1, 0, 5'd0, 0);
    step(1, 0, 1, 5'b11000, 0);
    if (pre_n < PRE_BITS / 2 || kind == K_OSTMO) return;
    step(1, 0, 1, 5'b11000, 0);
    step(1, 0, 1, 5'b11000, 0);
    step(1, 0, 1, 5'b10001, 1);
    for (int i = 0; i < n; i++) begin
      if (kind == K_EARLY && i == pos) begin step(1, 0, 1, EOP, 0); return; end
      if (kind == K_PTMO && i == pos) return;
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, TMO_CLKS - 6));
      step(1, 0, 1, rnd_sym(), 0);
    end
    if (kind == K_PTMO) return;
    step(1, 0, 1, (kind == K_GOOD) ? EOP : rnd_sym(), 0);
  endtask

  task automatic run_case(input string tag, input int pre_n, input int kind,
                          input int n, input int pos);
    logic [3:0] x;
    nsyms = CNT_W'(n);
    clr = 2'b11; idle(1); clr = 2'b00;
    idle(TMO_CLKS + 3);
    c_rst = 0; c_disc = 0; c_act = 0;
    send_msg(pre_n, kind, n, pos);
    idle(TMO_CLKS + 4);
    x = expect_of(pre_n, kind);
    chk({tag, " restart"}, c_rst, int'(x[3]));
    chk({tag, " discard"}, c_disc, int'(x[2]));
    chk({tag, " msgend"},  int'(mend), int'(x[1]));
    chk({tag, " err"},     int'(err),  int'(x[0]));
    if (x[3]) chk({tag, " no payload"}, c_act, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n_to;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset values
    chk("R1 act", int'(act), 0);
    chk("R1 restart", int'(rst_p), 0);
    chk("R1 discard", int'(disc), 0);
    chk("R1 flags", int'({mend, err}), 0);
    rst_n = 1; idle(1);

    // R2 activity before idle check completes is ignored
    c_rst = 0; c_act = 0;
    nsyms = CNT_W'(2);
    send_msg(40, K_GOOD, 2, 0);
    chk("R2 no payload", c_act, 0);
    chk("R2 no restart", c_rst, 0);
    chk("R2 no msgend", int'(mend), 0);
    idle(TMO_CLKS + 3);

    // R10 stray ordered-set pulse while idle
    c_act = 0;
    step(1, 0, 0, 5'd0, 1);
    idle(3);
    chk("R10 stray os", c_act, 0);
    idle(TMO_CLKS + 3);

    // directed endings
    run_case("R5 good", 64, K_GOOD, 4, 0);
    run_case("R5 good empty", 50, K_GOOD, 0, 0);
    run_case("R6 early", 64, K_EARLY, 6, 2);
    run_case("R6 early first", 64, K_EARLY, 6, 0);
    run_case("R7 bad eop", 64, K_BAD, 3, 0);
    run_case("R3 short 31", 31, K_GOOD, 3, 0);
    run_case("R3 edge 32", 32, K_GOOD, 3, 0);
    run_case("R4 os timeout", 64, K_OSTMO, 0, 0);
    run_case("R8 payload stall", 64, K_PTMO, 5, 3);

    // R8 exact timeout latency
    nsyms = CNT_W'(6);
    clr = 2'b11; idle(1); clr = 2'b00;
    idle(TMO_CLKS + 3);
    for (int i = 0; i < 40; i++) step(1, 1, 0, 5'd0, 0);
    step(1, 0, 1, 5'b11000, 0);
    step(1, 0, 1, 5'b10001, 1);
    step(1, 0, 1, rnd_sym(), 0);
    step(1, 0, 1, rnd_sym(), 0);
    n_to = 0;
    for (int i = 1; i <= 40; i++) begin
      step(0, 0, 0, 5'd0, 0);
      if (disc) begin n_to = i; break; end
    end
    chk("R8 timeout cycles", n_to, TMO_CLKS + 1);
    idle(TMO_CLKS + 3);

    // R9 per-bit clear
    run_case("R9 setup", 64, K_BAD, 2, 0);
    clr = 2'b10; idle(1); clr = 2'b00; idle(1);
    chk("R9 err cleared", int'(err), 0);
    chk("R9 msgend kept", int'(mend), 1);
    idle(3);
    chk("R9 msgend sticky", int'(mend), 1);
    clr = 2'b01; idle(1); clr = 2'b00; idle(1);
    chk("R9 msgend cleared", int'(mend), 0);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int k, pn, n, p;
      k  = $urandom_range(0, 4);
      pn = $urandom_range(20, 70);
      n  = $urandom_range(1, 20);
      p  = $urandom_range(0, n - 1);
      run_case($sformatf("R3/R4/R5/R6/R7/R8 rnd%0d", t), pn, k, n, p);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule